// File: doc/BRIEF.md
# Polled Register Access Bridge

The bridge lets a fast host reach registers in a slow, always-on domain that runs on its own clock. The host sees four 32-bit registers: control, transfer code, target address and data. To make a transfer, the host stages the code, the address and, for a write, the data word. It then writes 1 to control and polls control until it reads zero.

A start toggles a request bit. A two-flop synchronizer carries that bit into the slow clock domain. On the slow side, a request is raised on a simple request/acknowledge port and held until the target acknowledges it. The slow side then toggles an acknowledge bit, which returns to the host the same way. The host's busy flag drops once the synchronized acknowledge matches the request. For a read, the word captured on the slow side is then copied into the data register. That word cannot change until the next request, so it needs no multi-bit synchronizer.

Top module: `aon_reg_bridge`

## Requirements
- R1: After reset, all four host registers read zero: control at offset 0x0, code at 0x4, address at 0x8 and data at 0xC.
- R2: A host write of the value 1 to control while idle starts one transfer. From the next host cycle, control reads 1.
- R3: With code 0x00 the transfer is a read. Once control reads 0, the data register holds the word at the target address.
- R4: With code 0xF1 the transfer writes the full staged data word to the target address.
- R5: Code bit 0 selects write (1) or read (0). Code bits 7:4 enable bytes 3..0 of the word on a write, and bit 4 enables byte 0. Only the enabled bytes change at the target.
- R6: Host writes to the code, address or data registers while busy are ignored. Their read values are unchanged afterwards.
- R7: A second write of 1 to control while busy is ignored. Exactly one slow-side transfer takes place.
- R8: Control reads 0 only after the slow-side handshake for the transfer has completed.
- R9: The slow-side request, address, data and write flag hold steady from the raising of s_req until s_ack. The address presented equals the staged address.
- R10: Writing control with any value other than 1 starts no transfer, and control stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host clock |
| hrst_n | input | 1 | Host reset, active low |
| h_we | input | 1 | Host register write strobe |
| h_addr | input | 4 | Host register byte offset |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for h_addr |
| sclk | input | 1 | Slow domain clock |
| srst_n | input | 1 | Slow domain reset, active low |
| s_req | output | 1 | Slow-side request, held until s_ack |
| s_we | output | 1 | Request is a write |
| s_be | output | 4 | Byte enables for a write, zero for a read |
| s_addr | output | 32 | Target address |
| s_wdata | output | 32 | Write data |
| s_ack | input | 1 | Target acknowledge, one slow cycle |
| s_rdata | input | 32 | Target read data, valid with s_ack |

## Verification
The assertions assume the following about the inputs:
- The target raises s_ack only while s_req is high, for a single slow cycle.
- s_rdata is valid in the same cycle as s_ack.
- Both resets are applied together.

The bench target meets these by acknowledging after a fixed delay and dropping s_ack in the cycle after. The host stimulus follows the polling protocol, except where a test stages values or restarts while busy on purpose to show that such writes are ignored. Those tests probe the frozen state only through the host read path after the transfer has drained.

// File: rtl/aonb_pkg.sv
package aonb_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CODE = 2'd1,
    REG_ADDR = 2'd2,
    REG_DATA = 2'd3
  } reg_idx_e;

  localparam int CODE_W = 8;

  function automatic logic code_is_write(input logic [CODE_W-1:0] code);
    return code[0];
  endfunction

  function automatic logic [3:0] code_bytes(input logic [CODE_W-1:0] code);
    return code[0] ? code[7:4] : 4'b0000;
  endfunction
endpackage

// File: rtl/aonb_sync.sv
module aonb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/aonb_host_regs.sv
module aonb_host_regs
  import aonb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFFS_W = 4
) (
  input  logic              hclk,
  input  logic              hrst_n,
  input  logic              h_we,
  input  logic [OFFS_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  input  logic              ack_sync,
  input  logic [DATA_W-1:0] slow_rdata,
  output logic              req_tgl,
  output logic [CODE_W-1:0] code_q,
  output logic [DATA_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);
  logic     busy;
  reg_idx_e sel;
  logic     start_ev;
  logic     done_ev;
  logic     stage_ok;

  assign sel      = reg_idx_e'(h_addr[3:2]);
  assign stage_ok = h_we && !busy;
  assign start_ev = stage_ok && (sel == REG_CTRL) && (h_wdata == {{(DATA_W-1){1'b0}}, 1'b1});
  assign done_ev  = busy && (ack_sync == req_tgl);

  always_ff @(posedge hclk or negedge hrst_n) begin
    if (!hrst_n) begin
      busy    <= 1'b0;
      req_tgl <= 1'b0;
      code_q  <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      if (start_ev) begin
        busy    <= 1'b1;
        req_tgl <= ~req_tgl;
      end else if (done_ev) begin
        busy <= 1'b0;
        if (!code_is_write(code_q)) data_q <= slow_rdata;
      end
      if (stage_ok && sel == REG_CODE) code_q <= h_wdata[CODE_W-1:0];
      if (stage_ok && sel == REG_ADDR) addr_q <= h_wdata;
      if (stage_ok && sel == REG_DATA) data_q <= h_wdata;
    end
  end

  always_comb begin
    case (sel)
      REG_CTRL: h_rdata = {{(DATA_W-1){1'b0}}, busy};
      REG_CODE: h_rdata = {{(DATA_W-CODE_W){1'b0}}, code_q};
      REG_ADDR: h_rdata = addr_q;
      default:  h_rdata = data_q;
    endcase
  end

  p_start_toggle_r2: assert property (@(posedge hclk) disable iff (!hrst_n)
    $rose(busy) |-> (req_tgl != $past(req_tgl)));

  p_cfg_frozen_r6: assert property (@(posedge hclk) disable iff (!hrst_n)
    (busy && $past(busy)) |-> ($stable(code_q) && $stable(addr_q)));

  p_busy_wait_r8: assert property (@(posedge hclk) disable iff (!hrst_n)
    (busy && (ack_sync != req_tgl)) |=> busy);
endmodule

// File: rtl/aonb_slow_port.sv
module aonb_slow_port
  import aonb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              sclk,
  input  logic              srst_n,
  input  logic              req_sync,
  input  logic [CODE_W-1:0] code,
  input  logic [DATA_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ack_tgl,
  output logic [DATA_W-1:0] rdata_q,
  output logic              s_req,
  output logic              s_we,
  output logic [3:0]        s_be,
  output logic [DATA_W-1:0] s_addr,
  output logic [DATA_W-1:0] s_wdata,
  input  logic              s_ack,
  input  logic [DATA_W-1:0] s_rdata
);
  logic pending;
  logic accept_ev;

  assign pending   = (req_sync != ack_tgl);
  assign accept_ev = s_req && s_ack;

  always_ff @(posedge sclk or negedge srst_n) begin
    if (!srst_n) begin
      s_req   <= 1'b0;
      ack_tgl <= 1'b0;
      rdata_q <= '0;
    end else if (accept_ev) begin
      s_req   <= 1'b0;
      ack_tgl <= req_sync;
      if (!code_is_write(code)) rdata_q <= s_rdata;
    end else if (!s_req && pending) begin
      s_req <= 1'b1;
    end
  end

  assign s_we    = code_is_write(code);
  assign s_be    = code_bytes(code);
  assign s_addr  = addr;
  assign s_wdata = wdata;

  p_req_stable_r9: assert property (@(posedge sclk) disable iff (!srst_n)
    (s_req && !s_ack) |=> (s_req && $stable(s_addr) && $stable(s_wdata) && $stable(s_we)));

  p_req_pending_r7: assert property (@(posedge sclk) disable iff (!srst_n)
    s_req |-> (req_sync != ack_tgl));
endmodule

// File: rtl/aon_reg_bridge.sv
module aon_reg_bridge
  import aonb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFFS_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              hclk,
  input  logic              hrst_n,
  input  logic              h_we,
  input  logic [OFFS_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  input  logic              sclk,
  input  logic              srst_n,
  output logic              s_req,
  output logic              s_we,
  output logic [3:0]        s_be,
  output logic [DATA_W-1:0] s_addr,
  output logic [DATA_W-1:0] s_wdata,
  input  logic              s_ack,
  input  logic [DATA_W-1:0] s_rdata
);
  logic              req_tgl, req_sync, ack_tgl, ack_sync;
  logic [CODE_W-1:0] code_q;
  logic [DATA_W-1:0] addr_q, data_q, rdata_q;

  aonb_host_regs #(.DATA_W(DATA_W), .OFFS_W(OFFS_W)) u_host (
    .hclk(hclk), .hrst_n(hrst_n), .h_we(h_we), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .ack_sync(ack_sync),
    .slow_rdata(rdata_q), .req_tgl(req_tgl), .code_q(code_q),
    .addr_q(addr_q), .data_q(data_q)
  );

  aonb_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(sclk), .rst_n(srst_n), .d(req_tgl), .q(req_sync)
  );

  aonb_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(hclk), .rst_n(hrst_n), .d(ack_tgl), .q(ack_sync)
  );

  aonb_slow_port #(.DATA_W(DATA_W)) u_slow (
    .sclk(sclk), .srst_n(srst_n), .req_sync(req_sync), .code(code_q),
    .addr(addr_q), .wdata(data_q), .ack_tgl(ack_tgl), .rdata_q(rdata_q),
    .s_req(s_req), .s_we(s_we), .s_be(s_be), .s_addr(s_addr),
    .s_wdata(s_wdata), .s_ack(s_ack), .s_rdata(s_rdata)
  );
endmodule

// File: tb/aon_reg_bridge_tb.sv
`timescale 1ns/1ps
module aon_reg_bridge_tb_top;
  logic        hclk = 0, sclk = 0, hrst_n = 0, srst_n = 0;
  logic        h_we = 0;
  logic [3:0]  h_addr = 0;
  logic [31:0] h_wdata = 0, h_rdata;
  logic        s_req, s_we, s_ack;
  logic [3:0]  s_be;
  logic [31:0] s_addr, s_wdata, s_rdata;

  int tests = 0, fails = 0;
  int tx_count = 0;
  logic [31:0] last_addr;
  logic [31:0] tmem [16];
  logic [1:0]  lat;

  always #10 hclk = ~hclk;
  always #37 sclk = ~sclk;

  aon_reg_bridge dut_i (.*);

  function automatic logic [31:0] init_word(int i);
    return 32'hA5000000 ^ (i * 32'h01030507);
  endfunction

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  assign s_rdata = tmem[s_addr[5:2]];

  always @(posedge sclk) begin
    if (!srst_n) begin
      s_ack <= 0; lat <= 0;
      for (int i = 0; i < 16; i++) tmem[i] <= init_word(i);
    end else begin
      if (s_req && !s_ack) begin
        if (lat == 2) begin s_ack <= 1; lat <= 0; end
        else lat <= lat + 1;
      end else s_ack <= 0;
      if (s_req && s_ack) begin
        tx_count  <= tx_count + 1;
        last_addr <= s_addr;
        if (s_we)
          for (int b = 0; b < 4; b++)
            if (s_be[b]) tmem[s_addr[5:2]][8*b +: 8] <= s_wdata[8*b +: 8];
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [3:0] off, logic [31:0] v);
    @(negedge hclk); h_we = 1; h_addr = off; h_wdata = v;
    @(negedge hclk); h_we = 0;
  endtask

  task automatic hread(logic [3:0] off, output logic [31:0] v);
    @(negedge hclk); h_addr = off; #2 v = h_rdata;
  endtask

  task automatic poll();
    logic [31:0] v;
    for (int i = 0; i < 300; i++) begin
      hread(4'h0, v);
      if (v == 0) return;
    end
    check("R8 poll timeout", v, 0);
  endtask

  task automatic xfer(logic [7:0] code, logic [31:0] a, logic [31:0] d, bit wr_data);
    hwrite(4'h4, {24'h0, code});
    hwrite(4'h8, a);
    if (wr_data) hwrite(4'hC, d);
    hwrite(4'h0, 1);
    poll();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int r = 0; r < 4; r++) begin
      hread(4'(r*4), v); check("R1 reset", v, 0);
    end
  endtask

  task automatic t_read();
    logic [31:0] v; int n0 = tx_count;
    hwrite(4'h4, 0); hwrite(4'h8, 32'h14); hwrite(4'h0, 1);
    hread(4'h0, v); check("R2 busy after start", v, 1);
    poll();
    check("R8 done after handshake", tx_count, n0 + 1);
    hread(4'hC, v); check("R3 read data", v, init_word(5));
    check("R9 address at port", last_addr, 32'h14);
  endtask

  task automatic t_write_full();
    logic [31:0] v;
    xfer(8'hF1, 32'h8, 32'hDEADBEEF, 1);
    xfer(8'h00, 32'h8, 0, 0);
    hread(4'hC, v); check("R4 full write", v, 32'hDEADBEEF);
  endtask

  task automatic t_bytes();
    logic [31:0] v;
    xfer(8'h51, 32'h1C, 32'h11223344, 1);
    xfer(8'h00, 32'h1C, 0, 0);
    hread(4'hC, v); check("R5 byte enables", v, merge(init_word(7), 32'h11223344, 4'b0101));
    xfer(8'hA0, 32'h1C, 32'hFFFFFFFF, 1);
    xfer(8'h00, 32'h1C, 0, 0);
    hread(4'hC, v); check("R5 bit0 clear means read", v, merge(init_word(7), 32'h11223344, 4'b0101));
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    hwrite(4'h4, 0); hwrite(4'h8, 32'hC); hwrite(4'h0, 1);
    hwrite(4'h8, 32'h30); hwrite(4'h4, 32'hF1); hwrite(4'hC, 32'h55555555);
    poll();
    hread(4'h8, v); check("R6 addr frozen", v, 32'hC);
    hread(4'h4, v); check("R6 code frozen", v, 0);
    hread(4'hC, v); check("R6 data frozen", v, init_word(3));
  endtask

  task automatic t_double_start();
    int n0 = tx_count;
    hwrite(4'h4, 0); hwrite(4'h8, 32'h4); hwrite(4'h0, 1); hwrite(4'h0, 1);
    poll();
    repeat (40) @(negedge hclk);
    check("R7 one transfer", tx_count, n0 + 1);
  endtask

  task automatic t_ctrl_other();
    logic [31:0] v; int n0 = tx_count;
    hwrite(4'h0, 2);
    hread(4'h0, v); check("R10 ctrl stays 0", v, 0);
    repeat (40) @(negedge hclk);
    check("R10 no transfer", tx_count, n0);
  endtask

  initial begin
    repeat (5) @(posedge sclk);
    hrst_n = 1; srst_n = 1;
    repeat (3) @(posedge hclk);
    t_reset();
    t_read();
    t_write_full();
    t_bytes();
    t_busy_ignore();
    t_double_start();
    t_ctrl_other();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule